// File: doc/BRIEF.md
# Cascadable General-Purpose Timer with Input Capture

This block is a 16-bit up-counter with a selectable count source, a reference comparator that drives an output pin, and a capture register that snapshots the count on a chosen edge of an input pin. The counter can advance on every system clock, on a strobe from a free-running divide-by-16 prescaler, on each rising edge of the external input pin, or on the reference-match strobe of a neighbouring timer. That last source lets two instances be chained into a single 32-bit timer.

Software controls the block through a small word-wide register port. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational. When the count equals the reference value, the next count enable restarts the counter at zero, emits a one-cycle chain strobe and sets a sticky event flag. In the same edge the output pin either drops low for one cycle or inverts. The input pin passes through a two-flop synchronizer before any edge is detected.

Register map (3-bit address, 16-bit data):
- 0 control:
  - bit0 enable.
  - bits2:1 source: 00 system clock, 01 clock/16, 10 input pin, 11 chain input.
  - bits4:3 capture edge: 00 off, 01 rising, 10 falling, 11 both.
  - bit5 output mode: 0 low pulse, 1 toggle.
- 1 reference.
- 2 count (read-only).
- 3 capture (read-only).
- 4 status: bit0 reference event, bit1 capture event, each cleared by writing 1.
- Other addresses read zero.

Top module: `gp_timer`

## Requirements
- R1: After reset, the count, reference, control, capture and status registers read 0, `tout` is 1 and `evt` is 0.
- R2: With control bit0 set and source 00, the count rises by one on every clock edge after the write edge. With bit0 clear, the count holds.
- R3: With source 01, the count rises by exactly one per 16 clock edges, and so by exactly 10 over any 160 consecutive edges.
- R4: With source 10, each rising edge of `tin` adds one count, visible after the third clock edge following the change. Falling edges add nothing.
- R5: With source 11, the count rises by one on each clock edge where `casc_in` is high.
- R6: A count enable that arrives while the count equals the reference sets the count to 0 on that edge and sets status bit0. `casc_out` is high in the cycle before that edge, so a reference of N gives a period of N+1 enables.
- R7: In pulse mode (control bit5 = 0), `tout` is low for exactly the one cycle that follows each match edge and is high otherwise.
- R8: In toggle mode (control bit5 = 1), `tout` inverts on each match edge and keeps its level in between.
- R9: Each `tin` edge of the kind selected by control bits4:3 copies the current count into the capture register and sets status bit1. With 00, or with an edge of the other kind, nothing is captured and the flag stays as it was.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. `evt` is the OR of the two status bits.
- R11: Writes to the count address have no effect on the count.
- R12: When the `casc_out` of one instance with reference 0xFFFF drives the `casc_in` of a second instance on source 11, the pair counts as one 32-bit counter, with the second instance holding the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data |
| tin | input | 1 | External timer input pin (asynchronous) |
| tout | output | 1 | Compare output pin |
| casc_in | input | 1 | Count strobe from a lower timer |
| casc_out | output | 1 | Reference-match strobe to an upper timer |
| evt | output | 1 | Event flag, OR of status bits |

## Verification
Every result is sampled on the falling clock edge, after a known number of rising edges:
- A register write lands on the rising edge that follows the driven falling edge.
- The counter responds from the next rising edge onward.
- `casc_out` is already high on the falling edge before the match edge.
- `tout` and the status flag change on the match edge itself.
- A change on `tin` becomes visible in the count or the capture register only after the third rising edge.

The bench therefore samples after two edges, to prove nothing has moved yet, and again after three. The prescaler phase is unknown, so the divided source is checked over a 160-edge window, which contains exactly ten strobes.

// File: rtl/gptmr_pkg.sv
package gptmr_pkg;

    typedef enum logic [1:0] {
        SRC_SYS   = 2'b00,
        SRC_DIV   = 2'b01,
        SRC_PIN   = 2'b10,
        SRC_CHAIN = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'b00,
        CAP_RISE = 2'b01,
        CAP_FALL = 2'b10,
        CAP_BOTH = 2'b11
    } cap_e;

    typedef enum logic {
        OUT_PULSE  = 1'b0,
        OUT_TOGGLE = 1'b1
    } omode_e;

    typedef struct packed {
        omode_e omode;
        cap_e   cap;
        src_e   src;
        logic   en;
    } ctrl_t;

    typedef struct packed {
        logic cap_evt;
        logic ref_evt;
    } stat_t;

    localparam int          ADDR_W    = 3;
    localparam int          CTRL_W    = $bits(ctrl_t);
    localparam int          STAT_W    = $bits(stat_t);
    localparam logic [2:0]  A_CTRL    = 3'd0;
    localparam logic [2:0]  A_REF     = 3'd1;
    localparam logic [2:0]  A_COUNT   = 3'd2;
    localparam logic [2:0]  A_CAPTURE = 3'd3;
    localparam logic [2:0]  A_STATUS  = 3'd4;

    function automatic logic cap_hit(input cap_e mode, input logic rise, input logic fall);
        logic [1:0] m;
        m = mode;
        return (rise && m[0]) || (fall && m[1]);
    endfunction

endpackage

// File: rtl/gptmr_sync.sv
module gptmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SH_W-2:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/gptmr_prescale.sv
module gptmr_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign strobe = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)         pre_q <= '0;
        else if (strobe) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/gptmr_core.sv
module gptmr_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] ref_val,
    input  logic         toggle_mode,
    output logic [W-1:0] cnt,
    output logic         match,
    output logic         tout
);
    logic [W-1:0] cnt_q;

    assign match = tick && (cnt_q == ref_val);
    assign cnt   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (match) cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)              tout <= 1'b1;
        else if (toggle_mode) tout <= tout ^ match;
        else                  tout <= ~match;
    end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gptmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              tin,
    output logic              tout,
    input  logic              casc_in,
    output logic              casc_out,
    output logic              evt
);
    ctrl_t            ctrl_q;
    stat_t            stat_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pin_rise, pin_fall;
    logic             div_strobe;
    logic             src_strobe;
    logic             tick;
    logic             match;
    logic             out_toggle;
    logic             cap_fire;
    logic             wr_ctrl, wr_ref, wr_stat;

    gptmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (tin),
        .rise(pin_rise),
        .fall(pin_fall)
    );

    gptmr_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .strobe(div_strobe)
    );

    always_comb begin
        case (ctrl_q.src)
            SRC_SYS:   src_strobe = 1'b1;
            SRC_DIV:   src_strobe = div_strobe;
            SRC_PIN:   src_strobe = pin_rise;
            default:   src_strobe = casc_in;
        endcase
    end

    assign tick       = ctrl_q.en && src_strobe;
    assign out_toggle = (ctrl_q.omode == OUT_TOGGLE);

    gptmr_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .ref_val    (ref_q),
        .toggle_mode(out_toggle),
        .cnt        (cnt_q),
        .match      (match),
        .tout       (tout)
    );

    assign casc_out = match;

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_ref   = wr_en && (addr == A_REF);
    assign wr_stat  = wr_en && (addr == A_STATUS);
    assign cap_fire = cap_hit(ctrl_q.cap, pin_rise, pin_fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ref_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_ref)  ref_q  <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           cap_q <= '0;
        else if (cap_fire) cap_q <= cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.ref_evt <= match    | (stat_q.ref_evt & ~(wr_stat & wr_data[0]));
            stat_q.cap_evt <= cap_fire | (stat_q.cap_evt & ~(wr_stat & wr_data[1]));
        end
    end

    assign evt = stat_q.ref_evt | stat_q.cap_evt;

    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTRL:    rd_data[CTRL_W-1:0] = ctrl_q;
            A_REF:     rd_data = ref_q;
            A_COUNT:   rd_data = cnt_q;
            A_CAPTURE: rd_data = cap_q;
            A_STATUS:  rd_data[STAT_W-1:0] = stat_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tout,
    input logic             casc_out,
    input logic             evt,
    input logic [CNT_W-1:0] cnt,
    input logic             toggle_mode
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assert_match_restart_R6: assert property (@(posedge clk) disable iff (rst)
        casc_out |=> (cnt == '0));

    assert_match_flag_R10: assert property (@(posedge clk) disable iff (rst)
        casc_out |=> evt);

    assert_pulse_only_after_match_R7: assert property (@(posedge clk) disable iff (rst)
        (!toggle_mode && !$past(toggle_mode) && !tout) |-> $past(casc_out));

    assert_toggle_follows_match_R8: assert property (@(posedge clk) disable iff (rst)
        (toggle_mode && $past(toggle_mode)) |-> (tout == ($past(tout) ^ $past(casc_out))));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt == $past(cnt)) || (cnt == $past(cnt) + ONE) || (cnt == '0));
endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tout       (tout),
    .casc_out   (casc_out),
    .evt        (evt),
    .cnt        (cnt_q),
    .toggle_mode(out_toggle)
);

// File: tb/gp_timer_test.sv
`timescale 1ns/1ps
module gp_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_en_hi = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_lo, rd_hi;
    logic        tin = 1'b0;
    logic        casc_drv = 1'b0;
    logic        tout_lo, tout_hi, chain_lo, chain_hi, evt_lo, evt_hi;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    gp_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wdata),
        .rd_data(rd_lo), .tin(tin), .tout(tout_lo), .casc_in(casc_drv),
        .casc_out(chain_lo), .evt(evt_lo)
    );

    gp_timer uut_hi (
        .clk(clk), .rst(rst), .wr_en(wr_en_hi), .addr(addr), .wr_data(wdata),
        .rd_data(rd_hi), .tin(1'b0), .tout(tout_hi), .casc_in(chain_lo),
        .casc_out(chain_hi), .evt(evt_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge (or just after one)
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input bit hi, input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d;
        if (hi) wr_en_hi = 1'b1; else wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_en_hi = 1'b0;
    endtask

    task automatic rd(input bit hi, input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #0.5;
        d = hi ? rd_hi : rd_lo;
    endtask

    task automatic do_reset();
        rst = 1'b1; tin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        rd(0, 3'd2, v); check("R1 count", v, 0);
        rd(0, 3'd0, v); check("R1 ctrl", v, 0);
        rd(0, 3'd1, v); check("R1 ref", v, 0);
        rd(0, 3'd3, v); check("R1 capture", v, 0);
        rd(0, 3'd4, v); check("R1 status", v, 0);
        check("R1 tout", tout_lo, 1);
        check("R1 evt", evt_lo, 0);
    endtask

    task automatic t_sysclk();
        logic [15:0] v, held;
        do_reset();
        wr(0, 3'd1, 16'hFFFF);
        wr(0, 3'd0, 16'h0001);
        tick(25);
        rd(0, 3'd2, v); check("R2 count per clock", v, 25);
        wr(0, 3'd0, 16'h0000);
        rd(0, 3'd2, held);
        check("R2 last count at disable", held, 26);
        tick(10);
        rd(0, 3'd2, v); check("R2 hold when disabled", v, held);
        wr(0, 3'd2, 16'h1234);
        rd(0, 3'd2, v); check("R11 count write ignored", v, held);
    endtask

    task automatic t_div16();
        logic [15:0] v;
        do_reset();
        wr(0, 3'd1, 16'hFFFF);
        wr(0, 3'd0, 16'h0003);
        tick(160);
        rd(0, 3'd2, v); check("R3 ten counts in 160 clocks", v, 10);
    endtask

    task automatic t_pin();
        logic [15:0] v;
        do_reset();
        wr(0, 3'd1, 16'hFFFF);
        wr(0, 3'd0, 16'h0005);
        tin = 1'b1;
        tick(2);
        rd(0, 3'd2, v); check("R4 no count before third edge", v, 0);
        tick(1);
        rd(0, 3'd2, v); check("R4 count after third edge", v, 1);
        tin = 1'b0;
        tick(4);
        rd(0, 3'd2, v); check("R4 falling edge ignored", v, 1);
        for (int i = 0; i < 3; i++) begin
            tin = 1'b1; tick(4);
            tin = 1'b0; tick(4);
        end
        rd(0, 3'd2, v); check("R4 four rising edges", v, 4);
    endtask

    task automatic t_match_pulse();
        logic [15:0] v;
        do_reset();
        wr(0, 3'd1, 16'd4);
        wr(0, 3'd0, 16'h0001);
        tick(4);
        rd(0, 3'd2, v); check("R6 count reaches ref", v, 4);
        check("R6 chain strobe before match edge", chain_lo, 1);
        check("R7 tout high before match", tout_lo, 1);
        tick(1);
        rd(0, 3'd2, v); check("R6 restart at zero", v, 0);
        check("R7 tout low after match", tout_lo, 0);
        rd(0, 3'd4, v); check("R6 ref flag set", v, 1);
        tick(1);
        check("R7 pulse one cycle", tout_lo, 1);
        rd(0, 3'd2, v); check("R6 count after restart", v, 1);
        tick(4);
        check("R6 period ref+1", tout_lo, 0);
    endtask

    task automatic t_match_toggle();
        do_reset();
        wr(0, 3'd1, 16'd4);
        wr(0, 3'd0, 16'h0021);
        tick(5);
        check("R8 toggle to low", tout_lo, 0);
        tick(1);
        check("R8 level held", tout_lo, 0);
        tick(4);
        check("R8 toggle back high", tout_lo, 1);
    endtask

    task automatic t_capture();
        logic [15:0] v, frozen;
        do_reset();
        wr(0, 3'd1, 16'hFFFF);
        wr(0, 3'd0, 16'h0001);
        tick(7);
        wr(0, 3'd0, 16'h0008);           // disabled, capture on rising
        rd(0, 3'd2, frozen);
        tin = 1'b1; tick(2);
        rd(0, 3'd4, v); check("R9 no capture before third edge", v, 0);
        tick(1);
        rd(0, 3'd3, v); check("R9 capture value", v, frozen);
        rd(0, 3'd4, v); check("R9 capture flag", v, 2);
        check("R10 evt from capture", evt_lo, 1);
        tin = 1'b0; tick(3);
        wr(0, 3'd4, 16'h0000);
        rd(0, 3'd4, v); check("R10 write 0 keeps flag", v, 2);
        wr(0, 3'd4, 16'h0002);
        rd(0, 3'd4, v); check("R10 write 1 clears flag", v, 0);
        check("R10 evt cleared", evt_lo, 0);
        wr(0, 3'd0, 16'h0010);           // falling only
        tin = 1'b1; tick(3);
        rd(0, 3'd4, v); check("R9 rise ignored in fall mode", v, 0);
        tin = 1'b0; tick(3);
        rd(0, 3'd4, v); check("R9 fall captured", v, 2);
        wr(0, 3'd4, 16'h0002);
        wr(0, 3'd0, 16'h0000);           // capture off
        tin = 1'b1; tick(3); tin = 1'b0; tick(3);
        rd(0, 3'd4, v); check("R9 capture off", v, 0);
        wr(0, 3'd0, 16'h0018);           // both edges
        tin = 1'b1; tick(3);
        rd(0, 3'd4, v); check("R9 both: rise", v, 2);
        wr(0, 3'd4, 16'h0002);
        tin = 1'b0; tick(3);
        rd(0, 3'd4, v); check("R9 both: fall", v, 2);
    endtask

    task automatic t_chain();
        logic [15:0] v;
        do_reset();
        wr(1, 3'd1, 16'hFFFF);
        wr(1, 3'd0, 16'h0007);
        wr(0, 3'd1, 16'd3);
        wr(0, 3'd0, 16'h0001);
        tick(40);
        rd(1, 3'd2, v); check("R5 upper counts lower matches", v, 10);
    endtask

    task automatic t_wide();
        logic [15:0] lo, hi;
        do_reset();
        wr(1, 3'd1, 16'hFFFF);
        wr(1, 3'd0, 16'h0007);
        wr(0, 3'd1, 16'hFFFF);
        wr(0, 3'd0, 16'h0001);
        tick(70000);
        rd(0, 3'd2, lo);
        rd(1, 3'd2, hi);
        check("R12 32-bit count", {hi, lo}, 32'd70000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sysclk();
        t_div16();
        t_pin();
        t_match_pulse();
        t_match_toggle();
        t_capture();
        t_chain();
        t_wide();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule